// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block sits between an on-chip requester and a single-bit serial NOR flash. The requester presents one operation at a time: an operation select, a 24-bit byte address, a byte count and, for programming, a stream of write bytes. The block turns each request into one or more chip-select framed serial transactions. It generates the serial clock from the system clock and returns read bytes one per strobe. At the end it pulses `done`, and it raises `err` in the same cycle when the request failed.

The block drives all the modifying operations (page program, sector erase and chip erase) on its own from start to finish. It first sends a write-enable transaction. It then reads the status byte to confirm that the enable latch is set, sends the operation itself, and re-reads status until the busy bit drops. The requester therefore sees a single request and a single completion, however long the flash stays busy. A program request that would run past the end of a 256-byte page is refused before any serial activity. Two parameters choose between the two accepted opcodes for sector erase and the two for chip erase.

Top module: `spi_nor_host`

## Requirements
- R1: The serial link uses clock mode 0. `sclk` is low whenever `cs_n` is high. `mosi` changes only while `sclk` is low, and every byte goes out most significant bit first. `miso` is sampled when `sclk` rises.
- R2: `req_op` = 0 (plain read) sends one transaction with byte 0x03, then address bits 23:16, 15:8 and 7:0, then clocks in `req_len` bytes. Each byte is presented in arrival order on `rd_data` with a one-cycle `rd_valid` pulse.
- R3: `req_op` = 1 (fast read) sends 0x0B and the three address bytes, then one dummy byte whose received bits are discarded. It then returns `req_len` bytes as in R2.
- R4: `req_op` = 2 (identification) sends 0x9F with no address and returns `req_len` reply bytes. `req_op` = 3 (status) sends 0x05 with no address and returns `req_len` status bytes.
- R5: `req_op` = 4 (page program) runs, in order: a transaction carrying only 0x06; a 0x05 transaction reading one status byte; a transaction with 0x02, the three address bytes and `req_len` data bytes, each taken from `wr_data` in the cycle `wr_take` is high; then 0x05 transactions repeated until bit 0 of the returned byte is 0. After that `done` pulses with `err` low.
- R6: A request is refused without any `cs_n` activity, with `done` and `err` high in the following cycle, if any of these holds: a read or program with `req_len` of 0 or above 256; or a program where `req_addr[7:0]` + `req_len` exceeds 256. A program ending exactly on the page's last byte is accepted.
- R7: `req_op` = 5 (sector erase) runs the R5 sequence with the main transaction being an erase opcode plus the three address bytes. The opcode is 0x20 when `SE_ALT` = 0 and 0xD8 when `SE_ALT` = 1.
- R8: `req_op` = 6 (chip erase) runs the R5 sequence with a main transaction of only 0xC7 when `CE_ALT` = 1, or 0x60 when `CE_ALT` = 0.
- R9: If bit 1 of the status byte read after the write-enable transaction is 0, the sequence stops. No further transaction is sent, and `done` and `err` pulse together.
- R10: `cs_n` stays high for at least `CS_GAP` system clock cycles between any two transactions.
- R11: `req_op` = 7 (write disable) sends a single transaction carrying only 0x04 and finishes without any status polling.
- R12: After reset `cs_n` is 1, `sclk` is 0, and `busy`, `done` and `rd_valid` are 0. `busy` stays high from an accepted request until its `done`, and requests are only taken while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 3 | Operation select (0 to 7, see requirements) |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W (9) | Byte count for reads and program |
| wr_data | input | 8 | Program byte, consumed while `wr_take` is high |
| wr_take | output | 1 | Program byte consumed this cycle |
| rd_data | output | 8 | Received read byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with `done` |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The hardest condition to reach from the ports is an enable latch that fails to set, because a well-behaved flash always sets it after 0x06. The bench's flash model has a switch that makes it ignore the write-enable command. With that switch on, an erase request must stop after the status read and never send its opcode. The busy loop is reached the same way: the model keeps bit 0 set for a fixed number of status reads after each program or erase. The bench then checks the exact number of polls in the transaction log it records at the pins.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

  localparam int ADDR_W = 24;

  typedef enum logic [2:0] {
    OP_READ          = 3'd0,
    OP_FAST_READ     = 3'd1,
    OP_READ_ID       = 3'd2,
    OP_READ_STATUS   = 3'd3,
    OP_PROGRAM       = 3'd4,
    OP_SECTOR_ERASE  = 3'd5,
    OP_CHIP_ERASE    = 3'd6,
    OP_WRITE_DISABLE = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    STEP_WREN,
    STEP_WELCHK,
    STEP_MAIN,
    STEP_POLL
  } step_e;

  localparam logic [7:0] CODE_WREN  = 8'h06;
  localparam logic [7:0] CODE_WRDI  = 8'h04;
  localparam logic [7:0] CODE_RDID  = 8'h9F;
  localparam logic [7:0] CODE_RDST  = 8'h05;
  localparam logic [7:0] CODE_READ  = 8'h03;
  localparam logic [7:0] CODE_FREAD = 8'h0B;
  localparam logic [7:0] CODE_PROG  = 8'h02;

  // Operations that return bytes to the requester.
  function automatic logic op_reads(op_e op);
    return op inside {OP_READ, OP_FAST_READ, OP_READ_ID, OP_READ_STATUS};
  endfunction

  // Operations that modify the array and need enable + polling.
  function automatic logic op_modifies(op_e op);
    return op inside {OP_PROGRAM, OP_SECTOR_ERASE, OP_CHIP_ERASE};
  endfunction

  // Number of bytes before the data phase (opcode, address, dummy).
  function automatic logic [2:0] hdr_len(step_e s, op_e op);
    if (s != STEP_MAIN) return 3'd1;
    case (op)
      OP_READ, OP_PROGRAM, OP_SECTOR_ERASE: return 3'd4;
      OP_FAST_READ:                         return 3'd5;
      default:                              return 3'd1;
    endcase
  endfunction

  function automatic logic [7:0] main_code(op_e op, logic [7:0] se, logic [7:0] ce);
    case (op)
      OP_READ:          return CODE_READ;
      OP_FAST_READ:     return CODE_FREAD;
      OP_READ_ID:       return CODE_RDID;
      OP_READ_STATUS:   return CODE_RDST;
      OP_PROGRAM:       return CODE_PROG;
      OP_SECTOR_ERASE:  return se;
      OP_CHIP_ERASE:    return ce;
      default:          return CODE_WRDI;
    endcase
  endfunction

  // Header byte at position idx of the current transaction.
  function automatic logic [7:0] hdr_byte(step_e s, op_e op, logic [ADDR_W-1:0] a,
                                          logic [2:0] idx, logic [7:0] se, logic [7:0] ce);
    case (idx)
      3'd0: begin
        if (s == STEP_WREN)      return CODE_WREN;
        else if (s == STEP_MAIN) return main_code(op, se, ce);
        else                     return CODE_RDST;
      end
      3'd1:    return a[23:16];
      3'd2:    return a[15:8];
      3'd3:    return a[7:0];
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/spi_nor_shift.sv
module spi_nor_shift #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       done
);
  localparam int CNT_W = $clog2(CLK_DIV) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

  logic             active;
  logic             phase;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      rx     <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        phase  <= 1'b0;
        cnt    <= '0;
        bitn   <= '0;
        sh     <= tx;
      end else if (active) begin
        if (cnt == CNT_LAST) begin
          cnt <= '0;
          if (!phase) begin
            phase <= 1'b1;
            rx    <= {rx[6:0], miso};
          end else begin
            phase <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign sclk = active & phase;
  assign mosi = sh[7];

endmodule

// File: rtl/spi_nor_seq.sv
module spi_nor_seq
  import spi_nor_pkg::*;
#(
  parameter int CS_GAP     = 4,
  parameter int PAGE_BYTES = 256,
  parameter int LEN_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        se_code,
  input  logic [7:0]        ce_code,
  output logic              sh_start,
  output logic [7:0]        sh_tx,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  output logic              cs_n,
  output logic              wr_take,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              ev_reject,
  output logic              ev_wel_fail,
  output logic              ev_txn_end
);
  localparam int POS_W = LEN_W + 1;
  localparam int GAP_W = $clog2(CS_GAP + 1) + 1;
  localparam int OFF_W = $clog2(PAGE_BYTES);

  typedef enum logic [2:0] {ST_IDLE, ST_GAP, ST_LOAD, ST_WAIT, ST_END} st_e;

  st_e               state;
  op_e               op_q;
  step_e             step_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [POS_W-1:0]  pos_q;
  logic [GAP_W-1:0]  gap_q;
  logic [1:0]        stat_q;

  logic [POS_W-1:0]  hdr_n, data_n, total_n;
  logic              in_data, tx_is_wr, rx_is_data, rx_is_stat;
  op_e               op_in;

  // Legality of a request: length range and page containment.
  function automatic logic req_legal(op_e op, logic [ADDR_W-1:0] a, logic [LEN_W-1:0] n);
    int lo, cnt;
    lo  = int'(a[OFF_W-1:0]);
    cnt = int'(n);
    if (op_reads(op))      return (cnt != 0) && (cnt <= PAGE_BYTES);
    if (op == OP_PROGRAM)  return (cnt != 0) && (lo + cnt <= PAGE_BYTES);
    return 1'b1;
  endfunction

  assign op_in = op_e'(req_op);

  always_comb begin
    hdr_n = POS_W'(hdr_len(step_q, op_q));
    case (step_q)
      STEP_WREN: data_n = '0;
      STEP_MAIN: data_n = (op_reads(op_q) || op_q == OP_PROGRAM) ? POS_W'(len_q) : '0;
      default:   data_n = POS_W'(1);
    endcase
    total_n    = hdr_n + data_n;
    in_data    = pos_q >= hdr_n;
    tx_is_wr   = in_data && step_q == STEP_MAIN && op_q == OP_PROGRAM;
    rx_is_data = in_data && step_q == STEP_MAIN && op_reads(op_q);
    rx_is_stat = in_data && (step_q == STEP_WELCHK || step_q == STEP_POLL);
  end

  assign sh_start = state == ST_LOAD;
  assign wr_take  = sh_start && tx_is_wr;
  assign sh_tx    = tx_is_wr ? wr_data
                  : (in_data ? 8'h00 : hdr_byte(step_q, op_q, addr_q, pos_q[2:0], se_code, ce_code));
  assign busy        = state != ST_IDLE;
  assign ev_reject   = state == ST_IDLE && req_valid && !req_legal(op_in, req_addr, req_len);
  assign ev_wel_fail = state == ST_END && step_q == STEP_WELCHK && !stat_q[1];
  assign ev_txn_end  = state == ST_END;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= OP_READ;
      step_q   <= STEP_MAIN;
      addr_q   <= '0;
      len_q    <= '0;
      pos_q    <= '0;
      gap_q    <= '0;
      stat_q   <= '0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (!req_legal(op_in, req_addr, req_len)) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              op_q   <= op_in;
              addr_q <= req_addr;
              len_q  <= req_len;
              step_q <= op_modifies(op_in) ? STEP_WREN : STEP_MAIN;
              gap_q  <= '0;
              state  <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gap_q >= GAP_W'(CS_GAP - 1)) begin
            gap_q <= '0;
            pos_q <= '0;
            cs_n  <= 1'b0;
            state <= ST_LOAD;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_LOAD: state <= ST_WAIT;
        ST_WAIT: begin
          if (sh_done) begin
            if (rx_is_data) begin
              rd_valid <= 1'b1;
              rd_data  <= sh_rx;
            end
            if (rx_is_stat) stat_q <= sh_rx[1:0];
            pos_q <= pos_q + 1'b1;
            if (pos_q + 1'b1 == total_n) begin
              cs_n  <= 1'b1;
              state <= ST_END;
            end else begin
              state <= ST_LOAD;
            end
          end
        end
        ST_END: begin
          gap_q <= '0;
          case (step_q)
            STEP_WREN: begin
              step_q <= STEP_WELCHK;
              state  <= ST_GAP;
            end
            STEP_WELCHK: begin
              if (!stat_q[1]) begin
                done  <= 1'b1;
                err   <= 1'b1;
                state <= ST_IDLE;
              end else begin
                step_q <= STEP_MAIN;
                state  <= ST_GAP;
              end
            end
            STEP_MAIN: begin
              if (op_modifies(op_q)) begin
                step_q <= STEP_POLL;
                state  <= ST_GAP;
              end else begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end
            end
            default: begin
              if (stat_q[0]) begin
                state <= ST_GAP;
              end else begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_nor_host.sv
module spi_nor_host
  import spi_nor_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int CS_GAP     = 4,
  parameter int PAGE_BYTES = 256,
  parameter bit SE_ALT     = 1'b0,
  parameter bit CE_ALT     = 1'b0,
  localparam int LEN_W     = $clog2(PAGE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        wr_data,
  output logic              wr_take,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  logic [7:0] se_code, ce_code;
  logic       sh_start, sh_done;
  logic [7:0] sh_tx, sh_rx;
  logic       ev_reject, ev_wel_fail, ev_txn_end;

  generate
    if (SE_ALT) begin : g_se_alt
      assign se_code = 8'hD8;
    end else begin : g_se_std
      assign se_code = 8'h20;
    end
    if (CE_ALT) begin : g_ce_alt
      assign ce_code = 8'hC7;
    end else begin : g_ce_std
      assign ce_code = 8'h60;
    end
  endgenerate

  spi_nor_shift #(.CLK_DIV(CLK_DIV)) shift_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .tx    (sh_tx),
    .miso  (miso),
    .sclk  (sclk),
    .mosi  (mosi),
    .rx    (sh_rx),
    .done  (sh_done)
  );

  spi_nor_seq #(.CS_GAP(CS_GAP), .PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .wr_data     (wr_data),
    .se_code     (se_code),
    .ce_code     (ce_code),
    .sh_start    (sh_start),
    .sh_tx       (sh_tx),
    .sh_done     (sh_done),
    .sh_rx       (sh_rx),
    .cs_n        (cs_n),
    .wr_take     (wr_take),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .ev_reject   (ev_reject),
    .ev_wel_fail (ev_wel_fail),
    .ev_txn_end  (ev_txn_end)
  );

endmodule

// File: rtl/spi_nor_host_chk.sv
module spi_nor_host_chk #(
  parameter int CS_GAP = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic err,
  input logic rd_valid,
  input logic wr_take,
  input logic ev_reject,
  input logic ev_wel_fail,
  input logic ev_txn_end
);
  localparam int HC_W = $clog2(CS_GAP + 1) + 1;
  localparam logic [HC_W-1:0] HC_MAX = HC_W'(CS_GAP);

  logic [HC_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= HC_MAX;
    else if (!cs_n)     hi_cnt <= '0;
    else if (hi_cnt < HC_MAX) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R1
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi)); // R1
  AST_RD_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy && !wr_take); // R2
  AST_TXN_END_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txn_end |-> cs_n && busy); // R5
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> done && err && cs_n && !busy); // R6
  AST_WEL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wel_fail |=> done && err && !busy && cs_n); // R9
  AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_cnt >= HC_MAX); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && cs_n); // R12

endmodule

bind spi_nor_host spi_nor_host_chk #(.CS_GAP(CS_GAP)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .sclk        (sclk),
  .mosi        (mosi),
  .busy        (busy),
  .done        (done),
  .err         (err),
  .rd_valid    (rd_valid),
  .wr_take     (wr_take),
  .ev_reject   (ev_reject),
  .ev_wel_fail (ev_wel_fail),
  .ev_txn_end  (ev_txn_end)
);

// File: tb/spi_nor_host_tb_top.sv
`timescale 1ns/1ps
module spi_nor_host_tb_top;
  localparam int CS_GAP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [23:0] req_addr = '0;
  logic [8:0]  req_len = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_take, rd_valid, busy, done, err, sclk, cs_n, mosi;
  logic        miso = 1'b0;
  logic [7:0]  rd_data;

  always #2.5 clk = ~clk;

  spi_nor_host #(.CLK_DIV(2), .CS_GAP(CS_GAP), .SE_ALT(1'b0), .CE_ALT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .err(err),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0]  mem [0:1023];
  logic [7:0]  fl_status = 8'h00;
  int          busy_left = 0;
  bit          wel_block = 1'b0;
  logic [7:0]  cur [0:299];
  int          ncur = 0, bitc = 0;
  logic [7:0]  sh_in = '0, out_byte = '0, out_sh = '0;
  int          txn_n = 0;
  logic [7:0]  log_op [0:63];
  logic [23:0] log_addr [0:63];
  int          log_len [0:63];

  initial for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 13 + 5);

  function automatic logic [7:0] reply(int n);
    logic [9:0] a;
    a = {cur[2][1:0], cur[3]};
    case (cur[0])
      8'h03: return (n >= 4) ? mem[a + 10'(n - 4)] : 8'h00;
      8'h0B: return (n >= 5) ? mem[a + 10'(n - 5)] : 8'h00;
      8'h9F: return (n == 1) ? 8'hC2 : (n == 2) ? 8'h20 : (n == 3) ? 8'h16 : 8'hFF;
      8'h05: return fl_status;
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge cs_n) begin ncur = 0; bitc = 0; end

  always @(posedge sclk) if (!cs_n) begin
    sh_in = {sh_in[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      cur[ncur] = sh_in;
      ncur++;
      bitc = 0;
      out_byte = reply(ncur);
    end
  end

  always @(negedge sclk) if (!cs_n) begin
    if (bitc == 0) out_sh = out_byte;
    miso = out_sh[7];
    out_sh = {out_sh[6:0], 1'b0};
  end

  always @(posedge cs_n) if (ncur > 0 && txn_n < 64) begin
    log_op[txn_n]   = cur[0];
    log_addr[txn_n] = {cur[1], cur[2], cur[3]};
    log_len[txn_n]  = ncur;
    txn_n++;
    case (cur[0])
      8'h06: if (!wel_block) fl_status[1] = 1'b1;
      8'h04: fl_status[1] = 1'b0;
      8'h02: if (fl_status[1]) begin
        for (int k = 4; k < ncur; k++) mem[{cur[2][1:0], cur[3]} + 10'(k - 4)] = cur[k];
        fl_status[0] = 1'b1; busy_left = 3;
      end
      8'h20, 8'hD8, 8'h60, 8'hC7: if (fl_status[1]) begin
        fl_status[0] = 1'b1; busy_left = 2;
      end
      8'h05: if (fl_status[0]) begin
        busy_left--;
        if (busy_left == 0) fl_status = 8'h00;
      end
      default: ;
    endcase
  end

  // ---------------- scoreboard ----------------
  logic [7:0] exp_q[$];
  logic [7:0] wr_q[$];

  always @(negedge clk) if (rd_valid) begin
    if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected read byte", rd_data, 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(rd_data == e, "R2", "read byte", rd_data, e);
    end
  end

  initial forever begin
    @(negedge clk);
    if (wr_take) begin
      @(posedge clk); #1;
      if (wr_q.size() > 0) void'(wr_q.pop_front());
      wr_data = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
    end
  end

  // ---------------- pin monitors ----------------
  int r1_bad = 0, hi = 0, min_gap = 1000;
  bit seen_low = 1'b0, was_hi = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (cs_n && sclk) r1_bad++;
    if (!cs_n && was_hi && seen_low && hi < min_gap) min_gap = hi;
    if (!cs_n) seen_low = 1'b1;
    hi = cs_n ? hi + 1 : 0;
    was_hi = cs_n;
  end

  // ---------------- driver ----------------
  int base;
  logic last_err;

  task automatic run_op(input logic [2:0] op, input logic [23:0] a, input int n, input bit runs);
    base = txn_n;
    if (runs) begin
      for (int k = 0; k < n; k++) begin
        case (op)
          3'd0, 3'd1: exp_q.push_back(mem[a[9:0] + 10'(k)]);
          3'd2: exp_q.push_back(k == 0 ? 8'hC2 : k == 1 ? 8'h20 : k == 2 ? 8'h16 : 8'hFF);
          3'd3: exp_q.push_back(fl_status);
          default: ;
        endcase
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_len = 9'(n);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    last_err = err;
    @(negedge clk);
    chk(exp_q.size() == 0, "R2", "bytes still expected", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic exp_txn(input int idx, input logic [7:0] op, input int len, input string rq);
    chk(log_op[base + idx] == op, rq, "opcode", log_op[base + idx], op);
    chk(log_len[base + idx] == len, rq, "transaction length", log_len[base + idx], len);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "R12", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R12", "reset cs_n/sclk", {cs_n, sclk}, 2'b10);
    chk(busy == 1'b0 && done == 1'b0 && rd_valid == 1'b0, "R12", "reset busy/done", {busy, done, rd_valid}, 0);
    rst_n = 1'b1;

    // R2 plain read
    run_op(3'd0, 24'h000010, 4, 1'b1);
    exp_txn(0, 8'h03, 8, "R2");
    chk(log_addr[base] == 24'h000010, "R2", "address", log_addr[base], 24'h000010);
    chk(last_err == 1'b0, "R2", "err", last_err, 0);

    // R3 fast read with dummy byte
    run_op(3'd1, 24'h000123, 3, 1'b1);
    exp_txn(0, 8'h0B, 8, "R3");
    chk(log_addr[base] == 24'h000123, "R3", "address", log_addr[base], 24'h000123);

    // R4 identification and status
    run_op(3'd2, 24'h0, 3, 1'b1);
    exp_txn(0, 8'h9F, 4, "R4");
    run_op(3'd3, 24'h0, 2, 1'b1);
    exp_txn(0, 8'h05, 3, "R4");

    // R5 page program sequence and readback
    wr_q = '{8'hAA, 8'hBB, 8'hCC, 8'hDD};
    wr_data = wr_q[0];
    run_op(3'd4, 24'h000200, 4, 1'b1);
    chk(txn_n - base == 7, "R5", "transaction count", txn_n - base, 7);
    exp_txn(0, 8'h06, 1, "R5");
    exp_txn(1, 8'h05, 2, "R5");
    exp_txn(2, 8'h02, 8, "R5");
    chk(log_addr[base + 2] == 24'h000200, "R5", "address", log_addr[base + 2], 24'h000200);
    for (int p = 3; p < 7; p++) exp_txn(p, 8'h05, 2, "R5");
    chk(last_err == 1'b0, "R5", "err", last_err, 0);
    run_op(3'd0, 24'h000200, 4, 1'b1);
    chk(mem[10'h203] == 8'hDD, "R5", "programmed byte", mem[10'h203], 8'hDD);

    // R6 rejections and exact-fit boundary
    run_op(3'd4, 24'h0000FE, 4, 1'b0);
    chk(last_err == 1'b1, "R6", "page-cross err", last_err, 1);
    chk(txn_n == base, "R6", "no transaction on page cross", txn_n - base, 0);
    run_op(3'd0, 24'h000000, 0, 1'b0);
    chk(last_err == 1'b1 && txn_n == base, "R6", "zero-length read", {last_err, 8'(txn_n - base)}, 9'h100);
    wr_q = '{8'h11, 8'h22, 8'h33, 8'h44};
    wr_data = wr_q[0];
    run_op(3'd4, 24'h0000FC, 4, 1'b1);
    chk(last_err == 1'b0, "R6", "exact-fit program err", last_err, 0);
    chk(mem[10'h0FF] == 8'h44, "R6", "last page byte", mem[10'h0FF], 8'h44);

    // R7 sector erase
    run_op(3'd5, 24'h010000, 0, 1'b1);
    chk(txn_n - base == 6, "R7", "transaction count", txn_n - base, 6);
    exp_txn(2, 8'h20, 4, "R7");
    chk(log_addr[base + 2] == 24'h010000, "R7", "address", log_addr[base + 2], 24'h010000);
    exp_txn(5, 8'h05, 2, "R7");

    // R8 chip erase
    run_op(3'd6, 24'h0, 0, 1'b1);
    exp_txn(0, 8'h06, 1, "R8");
    exp_txn(2, 8'hC7, 1, "R8");
    chk(last_err == 1'b0 && txn_n - base == 6, "R8", "completion", txn_n - base, 6);

    // R9 enable latch never sets
    wel_block = 1'b1;
    run_op(3'd5, 24'h020000, 0, 1'b1);
    chk(last_err == 1'b1, "R9", "abort err", last_err, 1);
    chk(txn_n - base == 2, "R9", "only enable and status", txn_n - base, 2);
    wel_block = 1'b0;

    // R11 write disable
    run_op(3'd7, 24'h0, 0, 1'b1);
    chk(txn_n - base == 1, "R11", "single transaction", txn_n - base, 1);
    exp_txn(0, 8'h04, 1, "R11");

    // R10 and R1 from pin monitors
    chk(min_gap >= CS_GAP, "R10", "minimum cs_n high cycles", min_gap, CS_GAP);
    chk(r1_bad == 0, "R1", "sclk high while deselected", r1_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule